// File: doc/BRIEF.md
# Banked Interrupt Mask and Routing Unit

This unit gathers 32 level interrupt lines and, through a small 32-bit register bus, lets software enable, force and classify each line. Two consumers are served independently: the main processor and a coprocessor. Each has its own enable mask and its own class mask. A line counts as pending while its hardware input is high or its software force bit is set. Each pending line that is enabled for a consumer drives one of that consumer's two outputs. A class bit of 0 selects the normal interrupt output and a class bit of 1 selects the fast interrupt output.

The force register and both enable masks are reached in three ways: a plain-write address, a set alias that ORs the written word in, and a clear alias that removes every bit written as 1. Software can therefore change single bits without a read-modify-write sequence. A status address returns the lines that are currently routed to the main processor's fast output. Line n always occupies bit n of every per-line register.

Top module: `irq_bank_top`

## Requirements
- R1: A synchronous active-high reset clears the force, both enable and both class registers. After reset, bus_rdata is 0 and all four outputs are low, whatever hw_irq carries.
- R2: Line n uses bit n of every per-line register and of hw_irq. A line is pending when hw_irq[n] is 1 or force bit n is 1.
- R3: A write at a base address replaces the whole register: 0x14 force, 0x20 main enable, 0x2C main class, 0x30 coprocessor enable, 0x3C coprocessor class. A read of the same address returns the stored value.
- R4: A write at a set alias ORs bus_wdata into its register: 0x18 force, 0x24 main enable, 0x34 coprocessor enable.
- R5: A write at a clear alias (0x1C force, 0x28 main enable, 0x38 coprocessor enable) clears each bit that is 1 in bus_wdata and leaves the others unchanged. Writing all ones to 0x28 disables every main-processor line in one access.
- R6: A read of a set or clear alias returns the current value of its base register.
- R7: cpu_irq is the OR over lines that are pending, enabled in the main enable and have main class 0. cpu_fiq uses the same rule for main class 1.
- R8: cop_irq and cop_fiq follow the rule of R7 using the coprocessor enable and class registers, independently of the main registers.
- R9: A read at 0x08 returns the lines that are pending, enabled in the main enable and have main class 1.
- R10: A read at an undefined offset returns 0, and a write there changes no register. bus_rdata is registered: it shows the addressed value one clock edge after bus_rd is sampled high and is 0 after any edge at which bus_rd was low.
- R11: A force bit makes its line pending while hw_irq is low. Clearing the bit through 0x1C removes that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_irq | input | 32 | Hardware interrupt lines, level |
| cpu_irq | output | 1 | Main processor normal interrupt |
| cpu_fiq | output | 1 | Main processor fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |

## Verification
A register write takes effect at the clock edge that samples it. The four outputs follow the new value in the same cycle, and they follow hw_irq with no register in the path. Read data arrives one edge after the read strobe is sampled and returns to 0 at the next edge when no read is made. The bench drives every input half a period before an edge. It samples outputs half a period after the edge on which a write lands, and it samples read data half a period after the edge that registers it.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int NUM_TGT  = 2;

    // Stored register slots
    typedef enum int {
        RG_FORCE   = 0,
        RG_CPU_EN  = 1,
        RG_CPU_CLS = 2,
        RG_COP_EN  = 3,
        RG_COP_CLS = 4
    } reg_id_e;

    // Byte offsets seen by software
    localparam logic [ADDR_W-1:0] A_VFIQ      = 8'h08;
    localparam logic [ADDR_W-1:0] A_FORCE     = 8'h14;
    localparam logic [ADDR_W-1:0] A_FORCE_SET = 8'h18;
    localparam logic [ADDR_W-1:0] A_FORCE_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] A_CPU_EN    = 8'h20;
    localparam logic [ADDR_W-1:0] A_CPU_SET   = 8'h24;
    localparam logic [ADDR_W-1:0] A_CPU_CLR   = 8'h28;
    localparam logic [ADDR_W-1:0] A_CPU_CLS   = 8'h2C;
    localparam logic [ADDR_W-1:0] A_COP_EN    = 8'h30;
    localparam logic [ADDR_W-1:0] A_COP_SET   = 8'h34;
    localparam logic [ADDR_W-1:0] A_COP_CLR   = 8'h38;
    localparam logic [ADDR_W-1:0] A_COP_CLS   = 8'h3C;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGS
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    output logic [NR-1:0] w_dir,
    output logic [NR-1:0] w_set,
    output logic [NR-1:0] w_clr
);

    always_comb begin
        w_dir = '0;
        w_set = '0;
        w_clr = '0;
        if (wr_en) begin
            case (addr)
                A_FORCE:     w_dir[RG_FORCE]   = 1'b1;
                A_FORCE_SET: w_set[RG_FORCE]   = 1'b1;
                A_FORCE_CLR: w_clr[RG_FORCE]   = 1'b1;
                A_CPU_EN:    w_dir[RG_CPU_EN]  = 1'b1;
                A_CPU_SET:   w_set[RG_CPU_EN]  = 1'b1;
                A_CPU_CLR:   w_clr[RG_CPU_EN]  = 1'b1;
                A_CPU_CLS:   w_dir[RG_CPU_CLS] = 1'b1;
                A_COP_EN:    w_dir[RG_COP_EN]  = 1'b1;
                A_COP_SET:   w_set[RG_COP_EN]  = 1'b1;
                A_COP_CLR:   w_clr[RG_COP_EN]  = 1'b1;
                A_COP_CLS:   w_dir[RG_COP_CLS] = 1'b1;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/irq_bank_state_reg.sv
module irq_bank_state_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_dir,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;
    logic [W-1:0] nxt;

    // Clear is applied last so it wins over a set of the same bit
    always_comb begin
        set_m = wr_set ? wdata : '0;
        clr_m = wr_clr ? wdata : '0;
        nxt   = wr_dir ? wdata : q;
        nxt   = (nxt | set_m) & ~clr_m;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/irq_bank_route.sv
module irq_bank_route #(
    parameter int W = 32
) (
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    input  logic [W-1:0] cls,
    output logic         irq,
    output logic         fiq
);

    logic [W-1:0] live;

    assign live = pend & en;
    assign irq  = |(live & ~cls);
    assign fiq  = |(live & cls);

endmodule

// File: rtl/irq_bank_top.sv
module irq_bank_top
    import irq_bank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] hw_irq,
    output logic          cpu_irq,
    output logic          cpu_fiq,
    output logic          cop_irq,
    output logic          cop_fiq
);

    logic [NUM_REGS-1:0] w_dir;
    logic [NUM_REGS-1:0] w_set;
    logic [NUM_REGS-1:0] w_clr;
    logic [DW-1:0]       reg_q [NUM_REGS];
    logic [DW-1:0]       pending;
    logic [DW-1:0]       vfiq_vec;
    logic [DW-1:0]       rd_mux;
    logic [DW-1:0]       tgt_en  [NUM_TGT];
    logic [DW-1:0]       tgt_cls [NUM_TGT];
    logic [NUM_TGT-1:0]  tgt_irq;
    logic [NUM_TGT-1:0]  tgt_fiq;

    irq_bank_decode #(.AW(AW), .NR(NUM_REGS)) u_dec (
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .w_dir (w_dir),
        .w_set (w_set),
        .w_clr (w_clr)
    );

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            irq_bank_state_reg #(.W(DW)) u_reg (
                .clk    (clk),
                .rst    (rst),
                .wr_dir (w_dir[g]),
                .wr_set (w_set[g]),
                .wr_clr (w_clr[g]),
                .wdata  (bus_wdata),
                .q      (reg_q[g])
            );
        end
    endgenerate

    assign pending    = hw_irq | reg_q[RG_FORCE];
    assign tgt_en[0]  = reg_q[RG_CPU_EN];
    assign tgt_cls[0] = reg_q[RG_CPU_CLS];
    assign tgt_en[1]  = reg_q[RG_COP_EN];
    assign tgt_cls[1] = reg_q[RG_COP_CLS];

    generate
        for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
            irq_bank_route #(.W(DW)) u_route (
                .pend (pending),
                .en   (tgt_en[t]),
                .cls  (tgt_cls[t]),
                .irq  (tgt_irq[t]),
                .fiq  (tgt_fiq[t])
            );
        end
    endgenerate

    assign cpu_irq = tgt_irq[0];
    assign cpu_fiq = tgt_fiq[0];
    assign cop_irq = tgt_irq[1];
    assign cop_fiq = tgt_fiq[1];

    assign vfiq_vec = pending & reg_q[RG_CPU_EN] & reg_q[RG_CPU_CLS];

    always_comb begin
        case (bus_addr)
            A_VFIQ:                           rd_mux = vfiq_vec;
            A_FORCE, A_FORCE_SET, A_FORCE_CLR: rd_mux = reg_q[RG_FORCE];
            A_CPU_EN, A_CPU_SET, A_CPU_CLR:    rd_mux = reg_q[RG_CPU_EN];
            A_CPU_CLS:                         rd_mux = reg_q[RG_CPU_CLS];
            A_COP_EN, A_COP_SET, A_COP_CLR:    rd_mux = reg_q[RG_COP_EN];
            A_COP_CLS:                         rd_mux = reg_q[RG_COP_CLS];
            default:                           rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

endmodule

// File: rtl/irq_bank_checker.sv
module irq_bank_checker #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          cpu_irq,
    input logic          cpu_fiq,
    input logic          cop_irq,
    input logic          cop_fiq,
    input logic [DW-1:0] cpu_en_q
);

    // R1: reset leaves outputs quiet and read data zero
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && !cpu_irq && !cpu_fiq && !cop_irq && !cop_fiq));

    // R4: set alias ORs the written word into the main enable
    assert_set_alias_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h24) |=> cpu_en_q == ($past(cpu_en_q) | $past(bus_wdata)));

    // R5: clear alias removes written ones from the main enable
    assert_clr_alias_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h28) |=> cpu_en_q == ($past(cpu_en_q) & ~$past(bus_wdata)));

    // R5: an all-ones clear silences the main processor outputs
    assert_clear_all_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h28 && bus_wdata == '1) |=> (!cpu_irq && !cpu_fiq));

    // R10: no read strobe means zero read data next cycle
    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> bus_rdata == '0);

    // R10: undefined offsets read as zero
    assert_undef_read_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

endmodule

bind irq_bank_top irq_bank_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .cpu_fiq   (cpu_fiq),
    .cop_irq   (cop_irq),
    .cop_fiq   (cop_fiq),
    .cpu_en_q  (reg_q[irq_bank_pkg::RG_CPU_EN])
);

// File: tb/sim_irq_bank_top.sv
`timescale 1ns/1ps
module sim_irq_bank_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] hw_irq = '0;
    logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_bank_top u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_irq(hw_irq), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
        .cop_irq(cop_irq), .cop_fiq(cop_fiq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write lands at the next rising edge; return at the following falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Data registered at the edge between the two falling edges
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic outs_check(input string tag, input logic [3:0] exp);
        check(tag, {28'h0, cpu_irq, cpu_fiq, cop_irq, cop_fiq}, {28'h0, exp});
    endtask

    task automatic zero_all();
        wr(8'h14, 0); wr(8'h20, 0); wr(8'h2C, 0); wr(8'h30, 0); wr(8'h3C, 0);
        hw_irq = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hw_irq = '1;
        @(negedge clk);
        outs_check("R1 outputs after reset", 4'b0000);
        check("R1 rdata after reset", bus_rdata, 0);
        rd(8'h14, v); check("R1 force zero", v, 0);
        rd(8'h20, v); check("R1 cpu enable zero", v, 0);
        rd(8'h2C, v); check("R1 cpu class zero", v, 0);
        rd(8'h30, v); check("R1 cop enable zero", v, 0);
        rd(8'h3C, v); check("R1 cop class zero", v, 0);
        hw_irq = '0;
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(8'h20, 32'hA5A5_0F0F); rd(8'h20, v); check("R3 cpu enable direct", v, 32'hA5A5_0F0F);
        wr(8'h2C, 32'h1234_5678); rd(8'h2C, v); check("R3 cpu class direct", v, 32'h1234_5678);
        wr(8'h30, 32'h0000_FFFF); rd(8'h30, v); check("R3 cop enable direct", v, 32'h0000_FFFF);
        wr(8'h3C, 32'hFFFF_0000); rd(8'h3C, v); check("R3 cop class direct", v, 32'hFFFF_0000);
        wr(8'h14, 32'h8000_0001); rd(8'h14, v); check("R3 force direct", v, 32'h8000_0001);
        rd(8'h24, v); check("R6 cpu set alias read", v, 32'hA5A5_0F0F);
        rd(8'h28, v); check("R6 cpu clear alias read", v, 32'hA5A5_0F0F);
        rd(8'h34, v); check("R6 cop set alias read", v, 32'h0000_FFFF);
        rd(8'h1C, v); check("R6 force clear alias read", v, 32'h8000_0001);
        zero_all();
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'h20, 32'h0000_00F0);
        wr(8'h24, 32'h0000_0F01); rd(8'h20, v); check("R4 cpu set ORs", v, 32'h0000_0FF1);
        wr(8'h28, 32'h0000_0110); rd(8'h20, v); check("R5 cpu clear ones", v, 32'h0000_0EE1);
        wr(8'h34, 32'h00C0_0000); wr(8'h34, 32'h0003_0000);
        rd(8'h30, v); check("R4 cop set ORs", v, 32'h00C3_0000);
        wr(8'h38, 32'h0041_0000); rd(8'h30, v); check("R5 cop clear ones", v, 32'h0082_0000);
        wr(8'h18, 32'h0000_0006); rd(8'h14, v); check("R4 force set ORs", v, 32'h0000_0006);
        wr(8'h1C, 32'h0000_0002); rd(8'h14, v); check("R5 force clear ones", v, 32'h0000_0004);
        zero_all();
    endtask

    task automatic t_clear_all();
        logic [31:0] v;
        hw_irq = '1;
        wr(8'h2C, 32'hFFFF_0000);
        wr(8'h20, '1);
        outs_check("R7 both cpu outputs on", 4'b1100);
        wr(8'h28, '1);
        outs_check("R5 clear all quiets cpu", 4'b0000);
        rd(8'h20, v); check("R5 clear all enable", v, 0);
        zero_all();
    endtask

    task automatic t_route();
        hw_irq = 32'h0000_0020;
        wr(8'h20, 32'h0000_0020);
        outs_check("R7 class 0 to cpu irq", 4'b1000);
        wr(8'h2C, 32'h0000_0020);
        outs_check("R7 class 1 to cpu fiq", 4'b0100);
        hw_irq = 32'h0000_0040;
        #1 outs_check("R2 other line not enabled", 4'b0000);
        hw_irq = 32'h0000_0200;
        wr(8'h30, 32'h0000_0200);
        outs_check("R8 cop irq only", 4'b0010);
        wr(8'h3C, 32'h0000_0200);
        outs_check("R8 cop fiq only", 4'b0001);
        hw_irq = 32'h0000_0220;
        #1 outs_check("R8 targets independent", 4'b0101);
        zero_all();
    endtask

    task automatic t_force_vfiq();
        logic [31:0] v;
        wr(8'h20, 32'h0000_0108);
        wr(8'h2C, 32'h0000_0100);
        wr(8'h18, 32'h0000_0008);
        outs_check("R11 force drives irq", 4'b1000);
        wr(8'h1C, 32'h0000_0008);
        outs_check("R11 force clear removes", 4'b0000);
        hw_irq = 32'h0000_0108;
        wr(8'h18, 32'h0000_0001);
        rd(8'h08, v); check("R9 status read", v, 32'h0000_0100);
        wr(8'h24, 32'h0000_0001); wr(8'h2C, 32'h0000_0101);
        rd(8'h08, v); check("R9 status with forced line", v, 32'h0000_0101);
        zero_all();
    endtask

    task automatic t_undef();
        logic [31:0] v;
        wr(8'h20, 32'h0000_0033);
        wr(8'h10, '1); wr(8'h00, '1); wr(8'h40, '1);
        rd(8'h20, v); check("R10 undefined write ignored", v, 32'h0000_0033);
        rd(8'h14, v); check("R10 force unaffected", v, 0);
        rd(8'h10, v); check("R10 undefined read zero", v, 0);
        rd(8'h40, v); check("R10 read past map zero", v, 0);
        rd(8'h20, v);
        @(negedge clk); check("R10 idle rdata zero", bus_rdata, 0);
        zero_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_alias();
        t_clear_all();
        t_route();
        t_force_vfiq();
        t_undef();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule